// File: doc/BRIEF.md
# Round-Trip Latency Loopback Timer

This block sits between the receive FIFO and the transmit FIFO of a DMA link and measures how long a word takes to travel out over the link and come back. In normal operation it works as a plain loopback. Each word read from the receive side goes straight to the transmit side, and FIFO backpressure applies in both directions. The host keeps the loop filled with a constant fill word.

The host measures with a one-cycle arm pulse. On that pulse the block places a programmable marker word on the transmit side and clears and starts a cycle counter. The counter stops on the clock edge where the marker is accepted again from the receive side. The elapsed count then stays on the outputs with a done flag until the next arm pulse. The host converts the count into time; one count is one clock period, which is 4 ns at 250 MHz.

The counter saturates and does not wrap. If the marker is lost, the measurement ends with an overflow flag. A marker that returns is forwarded onward as the fill word. This keeps the marker out of the loop, so measurements can follow each other.

Top module: `rtt_loop_timer`

## Requirements
- R1: After reset, `elapsedCount` is 0 and `doneFlag` and `overflowFlag` are 0.
- R2: When no marker is being injected, `txValid` equals `rxValid`, `rxReady` equals `txReady`, and `txData` equals `rxData` for every word that is not the marker.
- R3: A receive word that matches `markerWord` on all `DATA_W` bits is forwarded on `txData` as `idleWord`. A word that differs from the marker in any single 32-bit lane is forwarded unchanged and does not stop the counter.
- R4: In the cycle where `armPulse` is high, `txValid` is 1, `txData` equals `markerWord` and `rxReady` is 0.
- R5: If `txReady` is 0 in the arm cycle, the marker stays on `txData` with `txValid` high, and `rxReady` stays 0, until a cycle with `txReady` high accepts it.
- R6: `elapsedCount` equals the number of clock edges from the arm edge to the edge where the marker is accepted on the receive side (`rxValid` and `rxReady` high).
- R7: `doneFlag` rises on the edge where the marker is accepted. After that, `doneFlag` and `elapsedCount` hold until the next arm.
- R8: If the marker has not returned within 2^CNT_W-1 edges, the count saturates at all ones. On edge 2^CNT_W after the arm, `doneFlag` and `overflowFlag` are both set.
- R9: An arm pulse clears `elapsedCount`, `doneFlag` and `overflowFlag` on its edge, which allows back-to-back measurements.
- R10: `idleWord` and `markerWord` are inputs that can change between measurements. A new marker value is detected in the same way as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per period |
| rstN | input | 1 | Synchronous reset, active low |
| idleWord | input | DATA_W | Fill word that replaces a returning marker |
| markerWord | input | DATA_W | Word injected at arm and detected on return |
| armPulse | input | 1 | One-cycle request that starts a measurement |
| rxValid | input | 1 | Receive FIFO has a word |
| rxData | input | DATA_W | Receive FIFO word |
| rxReady | output | 1 | Word is taken from the receive FIFO |
| txValid | output | 1 | Word offered to the transmit FIFO |
| txData | output | DATA_W | Word to the transmit FIFO |
| txReady | input | 1 | Transmit FIFO accepts a word |
| elapsedCount | output | CNT_W | Measured cycle count |
| doneFlag | output | 1 | Measurement finished |
| overflowFlag | output | 1 | Measurement ended by saturation |

## Verification
The loop is exercised in four ways:
- A short link with no backpressure shows that the count equals the return edge minus the arm edge.
- A longer link with periodic transmit stalls shows that cycles spent stalled are counted and that forwarding never drops or repeats a word.
- An arm that lands on a stalled transmit FIFO separates an injection that is held from one that is lost.
- A near-marker word in the loop, a changed marker value and a dropped marker show the difference between full-width matching and partial matching, and between a normal stop and saturation.

Re-arming immediately after each result checks that the flags are cleared.

// File: rtl/rtt_loop_pkg.sv
package rtt_loop_pkg;
  // Strobes sent from the control unit to the datapath each cycle.
  typedef struct packed {
    logic inject;    // marker owns the transmit side this cycle
    logic clearCnt;  // zero the counter on this edge
    logic countEn;   // advance the counter on this edge
  } loopStrobes_t;
endpackage

// File: rtl/rtt_loop_ctl.sv
module rtt_loop_ctl
  import rtt_loop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         armPulse,
  input  logic         txReady,
  input  logic         markerHit,
  input  logic         cntAtMax,
  output loopStrobes_t strobes,
  output logic         doneFlag,
  output logic         overflowFlag
);
  logic injectPending;
  logic running;
  logic doneQ;
  logic ovfQ;

  always_comb begin
    strobes.inject   = armPulse | injectPending;
    strobes.clearCnt = armPulse;
    strobes.countEn  = running & ~armPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      injectPending <= 1'b0;
      running       <= 1'b0;
      doneQ         <= 1'b0;
      ovfQ          <= 1'b0;
    end else if (armPulse) begin
      // A fresh arm restarts everything; the marker waits if tx is stalled.
      injectPending <= ~txReady;
      running       <= 1'b1;
      doneQ         <= 1'b0;
      ovfQ          <= 1'b0;
    end else begin
      if (injectPending && txReady) injectPending <= 1'b0;
      if (running && (markerHit || cntAtMax)) begin
        running <= 1'b0;
        doneQ   <= 1'b1;
        ovfQ    <= cntAtMax;
      end
    end
  end

  assign doneFlag     = doneQ;
  assign overflowFlag = ovfQ;
endmodule

// File: rtl/rtt_loop_dp.sv
module rtt_loop_dp
  import rtt_loop_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int LANE_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  loopStrobes_t      strobes,
  input  logic [DATA_W-1:0] idleWord,
  input  logic [DATA_W-1:0] markerWord,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  output logic              markerHit,
  output logic              cntAtMax,
  output logic [CNT_W-1:0]  elapsedCount
);
  localparam int LANES = DATA_W / LANE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LANES-1:0] laneEq;
  logic             rxIsMarker;
  logic [CNT_W-1:0] cnt;

  // Full-width match built from per-lane equality.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneEq[g] = (rxData[g*LANE_W +: LANE_W] == markerWord[g*LANE_W +: LANE_W]);
  end
  assign rxIsMarker = &laneEq;

  always_comb begin
    if (strobes.inject) begin
      txValid = 1'b1;
      txData  = markerWord;
      rxReady = 1'b0;
    end else begin
      txValid = rxValid;
      txData  = rxIsMarker ? idleWord : rxData;
      rxReady = txReady;
    end
  end

  assign markerHit = rxValid & rxReady & rxIsMarker;
  assign cntAtMax  = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN)                           cnt <= '0;
    else if (strobes.clearCnt)           cnt <= '0;
    else if (strobes.countEn && !cntAtMax) cnt <= cnt + 1'b1;
  end

  assign elapsedCount = cnt;
endmodule

// File: rtl/rtt_loop_timer.sv
module rtt_loop_timer
  import rtt_loop_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int LANE_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] idleWord,
  input  logic [DATA_W-1:0] markerWord,
  input  logic              armPulse,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  output logic [CNT_W-1:0]  elapsedCount,
  output logic              doneFlag,
  output logic              overflowFlag
);
  loopStrobes_t strobes;
  logic         markerHit;
  logic         cntAtMax;

  rtt_loop_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .armPulse     (armPulse),
    .txReady      (txReady),
    .markerHit    (markerHit),
    .cntAtMax     (cntAtMax),
    .strobes      (strobes),
    .doneFlag     (doneFlag),
    .overflowFlag (overflowFlag)
  );

  rtt_loop_dp #(.DATA_W(DATA_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .idleWord     (idleWord),
    .markerWord   (markerWord),
    .rxValid      (rxValid),
    .rxData       (rxData),
    .rxReady      (rxReady),
    .txValid      (txValid),
    .txData       (txData),
    .txReady      (txReady),
    .markerHit    (markerHit),
    .cntAtMax     (cntAtMax),
    .elapsedCount (elapsedCount)
  );
endmodule

// File: rtl/rtt_loop_timer_chk.sv
module rtt_loop_timer_chk #(
  parameter int DATA_W = 256,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              injectNow,
  input logic [DATA_W-1:0] idleWord,
  input logic [DATA_W-1:0] markerWord,
  input logic              armPulse,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              rxReady,
  input logic              txValid,
  input logic [DATA_W-1:0] txData,
  input logic              txReady,
  input logic [CNT_W-1:0]  elapsedCount,
  input logic              doneFlag,
  input logic              overflowFlag
);
  // R2
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rstN)
    !injectNow |-> (txValid == rxValid) && (rxReady == txReady));

  // R3
  p_marker_scrub_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!injectNow && rxValid && rxData == markerWord) |-> txData == idleWord);

  // R4
  p_inject_r4: assert property (@(posedge clk) disable iff (!rstN)
    armPulse |-> txValid && (txData == markerWord) && !rxReady);

  // R5
  p_hold_marker_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armPulse && !txReady) |=> txValid && (txData == markerWord) && !rxReady);

  // R7
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !armPulse) |=> doneFlag && $stable(elapsedCount));

  // R8
  p_ovf_sat_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |-> (&elapsedCount));

  // R9
  p_arm_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    armPulse |=> (elapsedCount == '0) && !doneFlag && !overflowFlag);
endmodule

bind rtt_loop_timer rtt_loop_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .injectNow    (strobes.inject),
  .idleWord     (idleWord),
  .markerWord   (markerWord),
  .armPulse     (armPulse),
  .rxValid      (rxValid),
  .rxData       (rxData),
  .rxReady      (rxReady),
  .txValid      (txValid),
  .txData       (txData),
  .txReady      (txReady),
  .elapsedCount (elapsedCount),
  .doneFlag     (doneFlag),
  .overflowFlag (overflowFlag)
);

// File: tb/rtt_loop_timer_tb.sv
module rtt_loop_timer_tb;
  localparam int DW = 256;
  localparam int CW = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] idleWord;
  logic [DW-1:0] markerWord;
  logic          armPulse = 1'b0;
  logic          rxValid = 1'b0;
  logic [DW-1:0] rxData = '0;
  logic          rxReady;
  logic          txValid;
  logic [DW-1:0] txData;
  logic          txReady = 1'b1;
  logic [CW-1:0] elapsedCount;
  logic          doneFlag;
  logic          overflowFlag;

  always #5 clk = ~clk;

  rtt_loop_timer #(.DATA_W(DW), .LANE_W(32), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .idleWord(idleWord), .markerWord(markerWord),
    .armPulse(armPulse), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .elapsedCount(elapsedCount), .doneFlag(doneFlag), .overflowFlag(overflowFlag)
  );

  int cyc = 0;
  always @(posedge clk) cyc++;

  // Link model and scoreboard state
  logic [DW-1:0] linkData[$];
  int            linkTime[$];
  int            expQ[$];
  int            linkLat = 4;
  int            bpMode = 0;
  int            bpHold = 0;
  bit            dropMarker = 0;
  bit            armReq = 0;
  bit            benchPend = 0;
  bit            measuring = 0;
  int            armCyc = 0;
  int            nChecks = 0;
  int            nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Link model: drives inputs at negedge, checks forwarding, books handshakes.
  initial begin
    forever begin
      @(negedge clk);
      if (bpHold > 0) begin
        txReady = 1'b0;
        bpHold--;
      end else if (bpMode == 1) txReady = ((cyc % 3) != 1);
      else txReady = 1'b1;
      rxValid = (linkData.size() > 0) && (linkTime[0] <= cyc + 1);
      rxData  = rxValid ? linkData[0] : '0;
      armPulse = armReq;
      if (armReq) begin
        armReq = 0;
        armCyc = cyc + 1;
        measuring = 1;
      end
      #1;
      if (rstN) begin
        if (armPulse || benchPend) begin
          check(txValid && txData == markerWord && !rxReady,
                benchPend ? "R5" : "R4", "marker on tx with rx stalled",
                {txValid, rxReady}, 2'b10);
          benchPend = !txReady;
        end else begin
          check(txValid == rxValid && rxReady == txReady, "R2", "valid/ready pass",
                {txValid, rxReady}, {rxValid, txReady});
          if (rxValid)
            check(txData == ((rxData == markerWord) ? idleWord : rxData),
                  (rxData == markerWord) ? "R3" : "R2", "forwarded word",
                  txData[63:0], ((rxData == markerWord) ? idleWord[63:0] : rxData[63:0]));
        end
        if (txValid && txReady && !(dropMarker && txData == markerWord)) begin
          linkData.push_back(txData);
          linkTime.push_back(cyc + 1 + linkLat);
        end
        if (rxValid && rxReady) begin
          if (measuring && rxData == markerWord) begin
            expQ.push_back(cyc + 1 - armCyc);
            measuring = 0;
          end
          void'(linkData.pop_front());
          void'(linkTime.pop_front());
        end
      end
    end
  end

  // Monitor: on each result compare with the queued expectation.
  initial begin
    forever begin
      @(posedge doneFlag);
      #2;
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "result without expectation", 0, 1);
      end else begin
        int e;
        int dly;
        e   = expQ.pop_front();
        dly = cyc - armCyc;
        check(elapsedCount == ((e > CMAX) ? CMAX : e), (e > CMAX) ? "R8" : "R6",
              "elapsed count", elapsedCount, (e > CMAX) ? CMAX : e);
        check(overflowFlag == (e > CMAX), "R8", "overflow flag", overflowFlag, (e > CMAX));
        check(dly == ((e > CMAX) ? CMAX + 1 : e), "R7", "done edge", dly,
              (e > CMAX) ? CMAX + 1 : e);
      end
    end
  end

  task automatic arm();
    armReq = 1;
    wait (armPulse == 1'b1);
    @(posedge clk);
    #2;
    check(elapsedCount == 0 && !doneFlag && !overflowFlag, "R9", "cleared after arm",
          {elapsedCount, doneFlag, overflowFlag}, 0);
  endtask

  task automatic waitDone();
    int n = 0;
    while (!doneFlag && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(doneFlag, "R7", "done held", doneFlag, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    idleWord   = {8{32'hA5A5_0001}};
    markerWord = {8{32'h5A5A_00FF}};
    for (int i = 0; i < 4; i++) begin
      linkData.push_back(idleWord);
      linkTime.push_back(0);
    end
    repeat (4) @(negedge clk);
    check(elapsedCount == 0 && !doneFlag && !overflowFlag, "R1", "reset state",
          {elapsedCount, doneFlag, overflowFlag}, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);

    // Short link, no stalls (R6)
    arm();
    waitDone();
    repeat (10) @(negedge clk);

    // Longer link with periodic stalls plus a near-marker word (R3, R6)
    linkLat = 17;
    bpMode  = 1;
    repeat (30) @(negedge clk);
    begin
      logic [DW-1:0] near;
      near = markerWord;
      near[DW-1 -: 32] = 32'h0000_1234;
      linkData.push_back(near);
      linkTime.push_back(cyc + 2);
    end
    arm();
    waitDone();

    // Arm into a stalled transmit FIFO (R5)
    bpMode = 0;
    repeat (20) @(negedge clk);
    bpHold = 4;
    arm();
    waitDone();

    // New marker value, back-to-back re-arm (R10, R9)
    markerWord = {8{32'h0F0F_7777}};
    linkLat    = 9;
    arm();
    waitDone();
    arm();
    waitDone();
    check(!overflowFlag, "R10", "second marker normal stop", overflowFlag, 0);

    // Lost marker: saturation (R8)
    dropMarker = 1;
    expQ.push_back(CMAX + 1);
    arm();
    measuring = 0;
    waitDone();
    check(overflowFlag && elapsedCount == CMAX, "R8", "saturated",
          {overflowFlag, elapsedCount}, {1'b1, CW'(CMAX)});
    dropMarker = 0;

    // Recovery after overflow (R9)
    arm();
    waitDone();
    check(!overflowFlag, "R9", "overflow cleared by re-arm", overflowFlag, 0);

    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule